// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the address for a four-beat memory burst. When either of two active-low address strobes is seen at a rising clock edge, it captures the full external address. The two least significant bits of that address become the burst start offset, and the beat index returns to zero. The upper bits are held in the load register and are passed to the output unchanged for the whole burst.

When neither strobe is active, an active-low advance input moves the burst to its next beat. When advance is inactive, the current address is held, which inserts wait states.

The order of the beats is set by a static order-select input. A low level selects linear order, which adds the beat index to the start offset modulo 4. A high level selects interleaved order, which XORs the start offset with the beat index. The order pin is active-low for linear order, so a net that is pulled up or left high gives interleaved order. The outputs are the full address and the current beat index. The memory array and the chip-select decode sit outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released, `addr_o` and `beat_o` are zero until the first load or advance.
- R2: If `strb_proc_n` or `strb_ctrl_n` (or both) is 0 at a rising edge, `addr_o` equals the `addr_i` sampled at that edge and `beat_o` is 0 after that edge.
- R3: A load at an edge takes priority over an advance (`adv_n` = 0) at the same edge.
- R4: With both strobes at 1 and `adv_n` = 0, `beat_o` increases by one at each edge.
- R5: With both strobes at 1 and `adv_n` = 1, `addr_o` and `beat_o` stay unchanged, whatever the value of `addr_i`.
- R6: With `order_i` = 0 (linear), `addr_o[1:0]` = (start + `beat_o`) mod 4.
- R7: With `order_i` = 1 (interleaved), `addr_o[1:0]` = start XOR `beat_o`. For example, start 11 gives 11, 10, 01, 00.
- R8: Between loads, `addr_o[ADDR_W-1:2]` stays equal to the upper bits that were loaded.
- R9: An advance from beat 3 wraps to beat 0 and returns the start address, so the same four-address sequence repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; assertion is asynchronous, release is synchronized |
| order_i | input | 1 | Static burst order: 0 = linear, 1 = interleaved |
| strb_proc_n | input | 1 | Active-low address strobe, first source |
| strb_ctrl_n | input | 1 | Active-low address strobe, second source |
| adv_n | input | 1 | Active-low burst advance |
| addr_i | input | ADDR_W | External address captured on a load |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Current beat index within the burst |

## Verification
Each piece of internal state appears at the ports on the edge after it goes wrong:
- A corrupted start offset shows on `addr_o[1:0]` at once, in both burst orders.
- A beat counter that skips, sticks or fails to clear shows on `beat_o`. It also shows on the low address bits, whose sequence stops following the linear or XOR rule.
- A load register that drops or alters the upper bits shows on `addr_o` above bit 1 in the cycle after the load, and it stays wrong until the next load.

Wrap-around, simultaneous load and advance, and held cycles with a changing `addr_i` are each checked on the edge right after they occur.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  localparam int BEATS  = 1 << BEAT_W;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_load_reg.sv
module burst_load_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic [ADDR_W-BEAT_W-1:0] upper_o,
  output logic [BEAT_W-1:0]        start_o
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic [UP_W-1:0]   upper_q, upper_d;
  logic [BEAT_W-1:0] start_q, start_d;

  // next state
  always_comb begin
    upper_d = addr_i[ADDR_W-1:BEAT_W];
    start_d = addr_i[BEAT_W-1:0];
  end

  // registers, enabled by load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
    end else if (load_i) begin
      upper_q <= upper_d;
      start_q <= start_d;
    end
  end

  assign upper_o = upper_q;
  assign start_o = start_q;

  // R8: without a load the captured upper bits do not move
  assert_upper_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(upper_q));

  // R2: a load captures the external address
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ({upper_q, start_q} == $past(addr_i)));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  output logic [BEAT_W-1:0] beat_o
);
  localparam logic [BEAT_W-1:0] ONE  = {{(BEAT_W-1){1'b0}}, 1'b1};
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              beat_en;

  // next state: a load clears the count and wins over an advance
  always_comb begin
    beat_en = load_i | adv_i;
    if (load_i) beat_d = '0;
    else        beat_d = beat_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assign beat_o = beat_q;

  // R4: an advance without a load steps the count by one
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> (beat_q == $past(beat_q) + ONE));

  // R5: with no load and no advance the count holds
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !load_i) |=> $stable(beat_q));

  // R3: a load together with an advance still clears the count
  assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && adv_i) |=> (beat_q == '0));

  // R9: the count wraps from the last beat back to zero
  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_q == LAST && adv_i && !load_i) |=> (beat_q == '0));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
(
  input  logic              order_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [BEAT_W-1:0] low_o
);
  order_e            ord;
  logic [BEAT_W-1:0] lin_off;
  logic [BEAT_W-1:0] ilv_off;

  assign ord     = order_e'(order_i);
  assign lin_off = start_i + beat_i;   // wraps modulo the burst length

  // interleaved order: each bit of the start offset is flipped by the matching beat bit
  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_off[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    case (ord)
      ORD_LINEAR: low_o = lin_off;
      default:    low_o = ilv_off;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              order_i,
  input  logic              strb_proc_n,
  input  logic              strb_ctrl_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        beat_o
);
  localparam int UP_W = ADDR_W - BEAT_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // decode of the strobes and the advance input
  logic load, step;
  assign load = ~strb_proc_n | ~strb_ctrl_n;
  assign step = ~adv_n & ~load;

  logic [UP_W-1:0]   upper;
  logic [BEAT_W-1:0] start;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] low;

  burst_load_reg #(.ADDR_W(ADDR_W)) u_load (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .load_i  (load),
    .addr_i  (addr_i),
    .upper_o (upper),
    .start_o (start)
  );

  burst_beat_ctr u_beat (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .load_i (load),
    .adv_i  (step),
    .beat_o (beat)
  );

  burst_order_map u_map (
    .order_i (order_i),
    .start_i (start),
    .beat_i  (beat),
    .low_o   (low)
  );

  assign addr_o = {upper, low};
  assign beat_o = beat;

  // R2: a strobe at an edge puts the sampled address on the output
  assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    load |=> (addr_o == $past(addr_i) && beat_o == '0));

  // R6: in linear order each advance adds one to the low address bits
  assert_linear_step_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (step && !order_i) |=> (!$stable(order_i) ||
      addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + BEAT_W'(1)));

  // R7: in interleaved order the low bits change by exactly the bits the beat changed
  assert_ilv_step_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (step && order_i) |=> (!$stable(order_i) ||
      (addr_o[BEAT_W-1:0] ^ $past(addr_o[BEAT_W-1:0])) == (beat_o ^ $past(beat_o))));

  // R8: the upper address bits only change on a load
  assert_upper_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !load |=> $stable(addr_o[ADDR_W-1:BEAT_W]));
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int AW = 17;
  localparam int VW = 4 + AW + AW + 2;
  localparam int NV = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          order_i = 1'b1;
  logic          strb_proc_n = 1'b1;
  logic          strb_ctrl_n = 1'b1;
  logic          adv_n = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .order_i(order_i), .strb_proc_n(strb_proc_n),
    .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n), .addr_i(addr_i),
    .addr_o(addr_o), .beat_o(beat_o)
  );

  // Each entry is {proc_n, ctrl_n, adv_n, order, addr_in, expected addr_o, expected beat_o}.
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'b0110, 17'h12346, 17'h12346, 2'd0},  // R2 load through the first strobe, linear order
    {4'b1100, 17'h00000, 17'h12347, 2'd1},  // R4 R6 step: 10 -> 11
    {4'b1100, 17'h00000, 17'h12344, 2'd2},  // R6 wraps to 00
    {4'b1100, 17'h00000, 17'h12345, 2'd3},  // R6 R8 upper bits kept
    {4'b1100, 17'h00000, 17'h12346, 2'd0},  // R9 wrap back to the start
    {4'b1110, 17'h1FFFF, 17'h12346, 2'd0},  // R5 hold, addr_in ignored
    {4'b1000, 17'h0ABC1, 17'h0ABC1, 2'd0},  // R3 second strobe together with advance
    {4'b0111, 17'h15553, 17'h15553, 2'd0},  // R2 load, interleaved, start 11
    {4'b1101, 17'h00000, 17'h15552, 2'd1},  // R7 11^01
    {4'b1111, 17'h0F0F0, 17'h15552, 2'd1},  // R5 hold in interleaved order
    {4'b1101, 17'h00000, 17'h15551, 2'd2},  // R7 11^10
    {4'b1101, 17'h00000, 17'h15550, 2'd3},  // R7 11^11
    {4'b1101, 17'h00000, 17'h15553, 2'd0},  // R9 repeat of the sequence
    {4'b0011, 17'h00001, 17'h00001, 2'd0},  // R2 both strobes low
    {4'b1101, 17'h00000, 17'h00000, 2'd1}   // R7 start 01: 01 -> 00
  };

  task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: outputs during reset and after its synchronized release
    repeat (3) @(negedge clk);
    chk("R1 addr in reset", addr_o, '0);
    chk("R1 beat in reset", {15'd0, beat_o}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 addr after release", addr_o, '0);
    chk("R1 beat after release", {15'd0, beat_o}, '0);

    // table walk: drive at the falling edge, check at the next falling edge
    for (int i = 0; i < NV; i++) begin
      {strb_proc_n, strb_ctrl_n, adv_n, order_i} = VEC[i][VW-1 -: 4];
      addr_i = VEC[i][AW+AW+1 -: AW];
      @(negedge clk);
      chk($sformatf("vec%0d addr", i), addr_o, VEC[i][AW+1 -: AW]);
      chk($sformatf("vec%0d beat", i), {15'd0, beat_o}, {15'd0, VEC[i][1:0]});
    end

    // R6: linear order from start 01 gives 01, 10, 11, 00
    order_i = 1'b0; strb_proc_n = 1'b0; adv_n = 1'b1; addr_i = 17'h00A01;
    @(negedge clk);
    strb_proc_n = 1'b1; adv_n = 1'b0;
    @(negedge clk); chk("R6 lin beat1", addr_o, 17'h00A02);
    @(negedge clk); chk("R6 lin beat2", addr_o, 17'h00A03);
    @(negedge clk); chk("R6 lin beat3", addr_o, 17'h00A00);
    adv_n = 1'b1;

    // R1: a reset in the middle of a burst clears the outputs at once
    #3 rst_n = 1'b0;
    #2 chk("R1 async clear addr", addr_o, '0);
    chk("R1 async clear beat", {15'd0, beat_o}, '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", addr_o, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule